// File: doc/BRIEF.md
# PCI target termination generator

This block drives the three target-side handshake lines of a PCI data transfer (device select, target ready and stop) for one transaction at a time. The target's control logic raises `claim` in the address phase to accept a transaction. In every data phase it then presents a `data_ready` level and a termination command. The block turns these into a legal pattern on the active-low bus lines. It watches the initiator's `frame_n` and `irdy_n` to see when a data phase completes and when the initiator ends the transaction.

The five ways a target may end a transaction are all supported: normal completion, retry, disconnect with data, disconnect without data and target abort. When the transaction ends, the block pulses `term_done` and reports the ending that actually went onto the bus. That report can differ from the request. A retry asked for after data has already moved is signalled as a disconnect without data, and `term_conv` marks that case. An abort asked for before device select has been driven is preceded by one cycle of device select. The address decode, the data path, parity and the buffering behind the target are handled elsewhere.

Command codes on `term_cmd`: 0 = none (keep transferring), 1 = retry, 2 = disconnect with data, 3 = disconnect without data, 4 = target abort. Codes 5 to 7 act as 0. Report codes on `term_kind`: 0 = normal, 1 = retry, 2 = disconnect with data, 3 = disconnect without data, 4 = target abort.

Top module: `pci_target_term`

## Requirements
- R1: During reset, and in every cycle with no transaction in progress, `devsel_n`, `trdy_n` and `stop_n` are high and `term_done` is low.
- R2: A `claim` while `frame_n` is low, with command 0 (or 5 to 7), asserts `devsel_n` in the next cycle. In each data phase without a termination command, `trdy_n` goes low in the cycle after `data_ready` was high and high in the cycle after it was low.
- R3: A data phase completes on a clock edge that sees `irdy_n` and `trdy_n` both low. If `frame_n` is high at that edge, all three outputs go high in the next cycle and `term_done` pulses with `term_kind` = 0.
- R4: A retry (command 1) issued before any data phase has completed drives `devsel_n` and `stop_n` low with `trdy_n` high, and the ending is reported with `term_kind` = 1.
- R5: A disconnect with data (command 2) drives all three outputs low. After the next completed data phase, `trdy_n` returns high while `devsel_n` and `stop_n` stay low. The ending is reported with `term_kind` = 2. The command input has no effect while this disconnect is in progress.
- R6: A disconnect without data (command 3) issued after a completed data phase drives `devsel_n` and `stop_n` low with `trdy_n` high, and is reported as `term_kind` = 3. Issued before any data phase has completed, the same command is signalled and reported as a retry (`term_kind` = 1).
- R7: A target abort (command 4) issued while `devsel_n` is already low drives `stop_n` low with `devsel_n` and `trdy_n` high in the next cycle, and is reported with `term_kind` = 4.
- R8: A target abort given together with `claim` first drives `devsel_n` low alone for exactly one cycle. The abort pattern of R7 follows in the cycle after.
- R9: A retry (command 1) issued after at least one data phase has completed is signalled and reported as a disconnect without data (`term_kind` = 3), with `term_conv` = 1. `term_conv` is 0 for every other ending.
- R10: Once `stop_n` is low it stays low for as long as `frame_n` is low. On the first edge that sees `frame_n` high, all outputs go high and `term_done` pulses for one cycle.
- R11: `trdy_n` is never low while `devsel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| claim | input | 1 | Target accepts the transaction whose address phase is on the bus |
| frame_n | input | 1 | Initiator frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| data_ready | input | 1 | Target can complete the next data phase |
| term_cmd | input | 3 | Termination command for the current data phase |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request, active low |
| term_done | output | 1 | One-cycle pulse when a transaction has ended |
| term_kind | output | 3 | Ending signalled on the bus, valid from the `term_done` pulse on |
| term_conv | output | 1 | Set when a requested retry was turned into a disconnect without data |

## Verification
The hardest case to reach is a retry command that arrives in the same cycle as a completing data phase, or after one. The conversion depends on whether a transfer already happened, and the abort-before-select rule depends on the cycle the command arrives in. Directed sequences set up each of these orderings explicitly: a claim with abort, a retry on the phase right after a transfer, and a disconnect without data before any transfer. Then several thousand cycles of seeded random initiator and command activity are run. The command mix is weighted toward "none" so that transactions live long enough to collect transfers before a termination command lands.

// File: rtl/tterm_pkg.sv
`timescale 1ns/1ps
package tterm_pkg;
  localparam int CMD_W  = 3;
  localparam int KIND_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE        = 3'd0,
    CMD_RETRY       = 3'd1,
    CMD_DISC_DATA   = 3'd2,
    CMD_DISC_NODATA = 3'd3,
    CMD_ABORT       = 3'd4
  } cmd_e;

  typedef enum logic [KIND_W-1:0] {
    END_NORMAL      = 3'd0,
    END_RETRY       = 3'd1,
    END_DISC_DATA   = 3'd2,
    END_DISC_NODATA = 3'd3,
    END_ABORT       = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DATA   = 3'd1,
    ST_DISC   = 3'd2,
    ST_PREDEV = 3'd3,
    ST_HOLD   = 3'd4
  } st_e;

  // Active-high view of the bus lines; inverted at the top-level pins.
  typedef struct packed {
    logic dev;
    logic rdy;
    logic stp;
  } drv_t;

  localparam drv_t DRV_OFF      = '{dev: 1'b0, rdy: 1'b0, stp: 1'b0};
  localparam drv_t DRV_SEL_ONLY = '{dev: 1'b1, rdy: 1'b0, stp: 1'b0};
  localparam drv_t DRV_SEL_STOP = '{dev: 1'b1, rdy: 1'b0, stp: 1'b1};
  localparam drv_t DRV_ALL      = '{dev: 1'b1, rdy: 1'b1, stp: 1'b1};
  localparam drv_t DRV_ABORT    = '{dev: 1'b0, rdy: 1'b0, stp: 1'b1};
endpackage

// File: rtl/tterm_rst_sync.sv
`timescale 1ns/1ps
module tterm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tterm_xfer_track.sv
`timescale 1ns/1ps
module tterm_xfer_track (
  input  logic clk,
  input  logic rst_n,
  input  logic in_idle,
  input  logic irdy_n,
  input  logic rdy_q,
  output logic xfer,
  output logic xfer_any
);
  logic seen_q;
  logic seen_d;
  logic seen_en;

  // A data phase completes when both ready lines are active at an edge.
  assign xfer     = ~irdy_n & rdy_q;
  assign xfer_any = seen_q | xfer;

  always_comb begin
    seen_d  = in_idle ? 1'b0 : xfer_any;
    seen_en = (seen_d != seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (seen_en) seen_q <= seen_d;
  end
endmodule

// File: rtl/tterm_next.sv
`timescale 1ns/1ps
module tterm_next
  import tterm_pkg::*;
(
  input  st_e   state_q,
  input  drv_t  drv_q,
  input  kind_e pend_kind_q,
  input  logic  pend_conv_q,
  input  logic  claim,
  input  logic  frame_n,
  input  logic  data_ready,
  input  cmd_e  cmd,
  input  logic  xfer,
  input  logic  xfer_any,
  output st_e   state_d,
  output drv_t  drv_d,
  output kind_e pend_kind_d,
  output logic  pend_conv_d,
  output logic  fin,
  output kind_e fin_kind,
  output logic  fin_conv
);
  always_comb begin
    state_d     = state_q;
    drv_d       = drv_q;
    pend_kind_d = pend_kind_q;
    pend_conv_d = pend_conv_q;
    fin         = 1'b0;
    fin_kind    = pend_kind_q;
    fin_conv    = pend_conv_q;

    unique case (state_q)
      ST_IDLE: begin
        if (claim && !frame_n) begin
          pend_conv_d = 1'b0;
          case (cmd)
            CMD_ABORT: begin
              // Select must be seen before the abort pattern.
              state_d     = ST_PREDEV;
              drv_d       = DRV_SEL_ONLY;
              pend_kind_d = END_ABORT;
            end
            CMD_RETRY, CMD_DISC_NODATA: begin
              // Nothing has moved yet: both endings are a retry.
              state_d     = ST_HOLD;
              drv_d       = DRV_SEL_STOP;
              pend_kind_d = END_RETRY;
            end
            CMD_DISC_DATA: begin
              state_d     = ST_DISC;
              drv_d       = DRV_ALL;
              pend_kind_d = END_DISC_DATA;
            end
            default: begin
              state_d     = ST_DATA;
              drv_d       = '{dev: 1'b1, rdy: data_ready, stp: 1'b0};
              pend_kind_d = END_NORMAL;
            end
          endcase
        end
      end

      ST_DATA: begin
        if (xfer && frame_n) begin
          state_d  = ST_IDLE;
          drv_d    = DRV_OFF;
          fin      = 1'b1;
          fin_kind = END_NORMAL;
          fin_conv = 1'b0;
        end else begin
          case (cmd)
            CMD_ABORT: begin
              state_d     = ST_HOLD;
              drv_d       = DRV_ABORT;
              pend_kind_d = END_ABORT;
            end
            CMD_RETRY: begin
              state_d     = ST_HOLD;
              drv_d       = DRV_SEL_STOP;
              pend_kind_d = xfer_any ? END_DISC_NODATA : END_RETRY;
              pend_conv_d = xfer_any;
            end
            CMD_DISC_NODATA: begin
              state_d     = ST_HOLD;
              drv_d       = DRV_SEL_STOP;
              pend_kind_d = xfer_any ? END_DISC_NODATA : END_RETRY;
              pend_conv_d = 1'b0;
            end
            CMD_DISC_DATA: begin
              state_d     = ST_DISC;
              drv_d       = DRV_ALL;
              pend_kind_d = END_DISC_DATA;
            end
            default: begin
              drv_d = '{dev: 1'b1, rdy: data_ready, stp: 1'b0};
            end
          endcase
        end
      end

      ST_DISC: begin
        if (xfer) begin
          if (frame_n) begin
            state_d = ST_IDLE;
            drv_d   = DRV_OFF;
            fin     = 1'b1;
          end else begin
            state_d = ST_HOLD;
            drv_d   = DRV_SEL_STOP;
          end
        end
      end

      ST_PREDEV: begin
        state_d = ST_HOLD;
        drv_d   = DRV_ABORT;
      end

      ST_HOLD: begin
        if (frame_n) begin
          state_d = ST_IDLE;
          drv_d   = DRV_OFF;
          fin     = 1'b1;
        end
      end

      default: begin
        state_d = ST_IDLE;
        drv_d   = DRV_OFF;
      end
    endcase
  end
endmodule

// File: rtl/tterm_regs.sv
`timescale 1ns/1ps
module tterm_regs
  import tterm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  st_e   state_d,
  input  drv_t  drv_d,
  input  kind_e pend_kind_d,
  input  logic  pend_conv_d,
  input  logic  fin,
  input  kind_e fin_kind,
  input  logic  fin_conv,
  output st_e   state_q,
  output drv_t  drv_q,
  output kind_e pend_kind_q,
  output logic  pend_conv_q,
  output logic  done_q,
  output kind_e kind_q,
  output logic  conv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      drv_q       <= DRV_OFF;
      pend_kind_q <= END_NORMAL;
      pend_conv_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      drv_q       <= drv_d;
      pend_kind_q <= pend_kind_d;
      pend_conv_q <= pend_conv_d;
      done_q      <= fin;
    end
  end

  // Report registers load only when a transaction ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= END_NORMAL;
      conv_q <= 1'b0;
    end else if (fin) begin
      kind_q <= fin_kind;
      conv_q <= fin_conv;
    end
  end
endmodule

// File: rtl/pci_target_term.sv
`timescale 1ns/1ps
module pci_target_term
  import tterm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              data_ready,
  input  logic [CMD_W-1:0]  term_cmd,
  output logic              devsel_n,
  output logic              trdy_n,
  output logic              stop_n,
  output logic              term_done,
  output logic [KIND_W-1:0] term_kind,
  output logic              term_conv
);
  logic  rst_sync_n;
  st_e   state_q, state_d;
  drv_t  drv_q, drv_d;
  kind_e pend_kind_q, pend_kind_d;
  logic  pend_conv_q, pend_conv_d;
  logic  fin, fin_conv;
  kind_e fin_kind;
  logic  xfer, xfer_any;
  logic  done_q, conv_q;
  kind_e kind_q;
  cmd_e  cmd;

  always_comb begin
    unique case (term_cmd)
      3'd1:    cmd = CMD_RETRY;
      3'd2:    cmd = CMD_DISC_DATA;
      3'd3:    cmd = CMD_DISC_NODATA;
      3'd4:    cmd = CMD_ABORT;
      default: cmd = CMD_NONE;
    endcase
  end

  tterm_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tterm_xfer_track i_xfer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_idle  (state_q == ST_IDLE),
    .irdy_n   (irdy_n),
    .rdy_q    (drv_q.rdy),
    .xfer     (xfer),
    .xfer_any (xfer_any)
  );

  tterm_next i_next (
    .state_q     (state_q),
    .drv_q       (drv_q),
    .pend_kind_q (pend_kind_q),
    .pend_conv_q (pend_conv_q),
    .claim       (claim),
    .frame_n     (frame_n),
    .data_ready  (data_ready),
    .cmd         (cmd),
    .xfer        (xfer),
    .xfer_any    (xfer_any),
    .state_d     (state_d),
    .drv_d       (drv_d),
    .pend_kind_d (pend_kind_d),
    .pend_conv_d (pend_conv_d),
    .fin         (fin),
    .fin_kind    (fin_kind),
    .fin_conv    (fin_conv)
  );

  tterm_regs i_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .state_d     (state_d),
    .drv_d       (drv_d),
    .pend_kind_d (pend_kind_d),
    .pend_conv_d (pend_conv_d),
    .fin         (fin),
    .fin_kind    (fin_kind),
    .fin_conv    (fin_conv),
    .state_q     (state_q),
    .drv_q       (drv_q),
    .pend_kind_q (pend_kind_q),
    .pend_conv_q (pend_conv_q),
    .done_q      (done_q),
    .kind_q      (kind_q),
    .conv_q      (conv_q)
  );

  assign devsel_n  = ~drv_q.dev;
  assign trdy_n    = ~drv_q.rdy;
  assign stop_n    = ~drv_q.stp;
  assign term_done = done_q;
  assign term_kind = kind_q;
  assign term_conv = conv_q;
endmodule

// File: rtl/tterm_checker.sv
`timescale 1ns/1ps
module tterm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic       irdy_n,
  input logic       devsel_n,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       term_done,
  input logic [2:0] term_kind,
  input logic       term_conv
);
  // Transfer history seen at the pins since the last reported ending.
  logic moved_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    moved_q <= 1'b0;
    else if (term_done)            moved_q <= 1'b0;
    else if (!irdy_n && !trdy_n)   moved_q <= 1'b1;
  end

  assert_ready_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && devsel_n));

  assert_abort_after_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_n) && devsel_n) |-> $past(!devsel_n));

  assert_stop_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !frame_n) |=> !stop_n);

  assert_done_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_done |-> (devsel_n && trdy_n && stop_n));

  assert_retry_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (term_done && term_kind == 3'd1) |-> !moved_q);

  assert_disc_nodata_after_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_done && term_kind == 3'd3) |-> moved_q);

  assert_conv_kind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (term_done && term_conv) |-> (term_kind == 3'd3));

  assert_disc_data_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && !trdy_n && !irdy_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n));
endmodule

bind pci_target_term tterm_checker i_tterm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_n   (frame_n),
  .irdy_n    (irdy_n),
  .devsel_n  (devsel_n),
  .trdy_n    (trdy_n),
  .stop_n    (stop_n),
  .term_done (term_done),
  .term_kind (term_kind),
  .term_conv (term_conv)
);

// File: tb/test_pci_target_term.sv
`timescale 1ns/1ps
module test_pci_target_term;
  logic       clk;
  logic       rst_n;
  logic       claim;
  logic       frame_n;
  logic       irdy_n;
  logic       data_ready;
  logic [2:0] term_cmd;
  logic       devsel_n, trdy_n, stop_n, term_done, term_conv;
  logic [2:0] term_kind;

  int n_chk;
  int n_bad;
  bit finished;

  pci_target_term i_pci_target_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .claim      (claim),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .data_ready (data_ready),
    .term_cmd   (term_cmd),
    .devsel_n   (devsel_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .term_done  (term_done),
    .term_kind  (term_kind),
    .term_conv  (term_conv)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model state, written from the requirements.
  int    m_st;   // 0 idle, 1 data, 2 disc-with-data, 3 select-before-abort, 4 stop hold
  bit    m_dev, m_rdy, m_stp, m_seen, m_done, m_pc, m_conv;
  int    m_pk, m_kind;
  string m_tag;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit cl, input bit fr_n, input bit ir_n, input bit rd, input int cmd_in);
    bit x, any, fin, fc;
    int c, ns, fk;
    bit nd, nr, np;
    x   = !ir_n && m_rdy;
    any = m_seen || x;
    c   = (cmd_in > 4) ? 0 : cmd_in;
    ns = m_st; nd = m_dev; nr = m_rdy; np = m_stp;
    fin = 0; fk = m_pk; fc = m_pc;
    m_tag = "R1";
    case (m_st)
      0: if (cl && !fr_n) begin
        m_pc = 0;
        case (c)
          4: begin ns = 3; nd = 1; nr = 0; np = 0; m_pk = 4; m_tag = "R8"; end
          1, 3: begin ns = 4; nd = 1; nr = 0; np = 1; m_pk = 1; m_tag = (c == 1) ? "R4" : "R6"; end
          2: begin ns = 2; nd = 1; nr = 1; np = 1; m_pk = 2; m_tag = "R5"; end
          default: begin ns = 1; nd = 1; nr = rd; np = 0; m_pk = 0; m_tag = "R2"; end
        endcase
      end
      1: if (x && fr_n) begin
        fin = 1; fk = 0; fc = 0; m_tag = "R3";
      end else begin
        case (c)
          4: begin ns = 4; nd = 0; nr = 0; np = 1; m_pk = 4; m_tag = "R7"; end
          1: begin ns = 4; nd = 1; nr = 0; np = 1; m_pk = any ? 3 : 1; m_pc = any;
                   m_tag = any ? "R9" : "R4"; end
          3: begin ns = 4; nd = 1; nr = 0; np = 1; m_pk = any ? 3 : 1; m_pc = 0; m_tag = "R6"; end
          2: begin ns = 2; nd = 1; nr = 1; np = 1; m_pk = 2; m_tag = "R5"; end
          default: begin nr = rd; m_tag = "R2"; end
        endcase
      end
      2: begin
        m_tag = "R5";
        if (x) begin
          if (fr_n) begin fin = 1; fk = m_pk; fc = m_pc; end
          else begin ns = 4; nd = 1; nr = 0; np = 1; end
        end
      end
      3: begin ns = 4; nd = 0; nr = 0; np = 1; m_tag = "R8"; end
      default: begin
        m_tag = "R10";
        if (fr_n) begin fin = 1; fk = m_pk; fc = m_pc; end
      end
    endcase
    if (fin) begin ns = 0; nd = 0; nr = 0; np = 0; m_kind = fk; m_conv = fc; end
    m_seen = (m_st == 0) ? 1'b0 : any;
    m_st = ns; m_dev = nd; m_rdy = nr; m_stp = np; m_done = fin;
  endtask

  // Drive one cycle at the falling edge, then compare at the next falling edge.
  task automatic step(input bit cl, input bit fr_n, input bit ir_n, input bit rd, input int cmd_in,
                      input string tag_over);
    string tag;
    claim = cl; frame_n = fr_n; irdy_n = ir_n; data_ready = rd; term_cmd = 3'(cmd_in);
    model_step(cl, fr_n, ir_n, rd, cmd_in);
    tag = (tag_over != "") ? tag_over : m_tag;
    @(posedge clk);
    @(negedge clk);
    chk(devsel_n, !m_dev, tag, "devsel_n");
    chk(trdy_n, !m_rdy, tag, "trdy_n");
    chk(stop_n, !m_stp, tag, "stop_n");
    chk(term_done, m_done, tag, "term_done");
    chk(term_kind, m_kind, tag, "term_kind");
    chk(term_conv, m_conv, tag, "term_conv");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 0;
    m_st = 0; m_dev = 0; m_rdy = 0; m_stp = 0; m_seen = 0; m_done = 0;
    m_pc = 0; m_conv = 0; m_pk = 0; m_kind = 0;
    rst_n = 1'b0; claim = 0; frame_n = 1; irdy_n = 1; data_ready = 0; term_cmd = 0;
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    // R1: lines idle while in reset
    chk(devsel_n, 1, "R1", "devsel_n in reset");
    chk(trdy_n, 1, "R1", "trdy_n in reset");
    chk(stop_n, 1, "R1", "stop_n in reset");
    chk(term_done, 0, "R1", "term_done in reset");
    rst_n = 1'b1;
    repeat (4) step(0, 1, 1, 0, 0, "R1");

    // R2/R3: claim, one wait phase, then a single last transfer
    step(1, 0, 1, 0, 0, "R2");
    step(0, 1, 0, 1, 0, "R2");
    step(0, 1, 0, 0, 0, "R3");
    step(0, 1, 1, 0, 0, "R3");

    // R8: abort requested together with claim
    step(1, 0, 1, 0, 4, "R8");
    step(0, 0, 1, 0, 0, "R8");
    step(0, 0, 1, 0, 0, "R10");
    step(0, 1, 1, 0, 0, "R10");
    step(0, 1, 1, 0, 0, "R1");

    // R9: retry in the phase where data completes
    step(1, 0, 1, 1, 0, "R2");
    step(0, 0, 0, 1, 1, "R9");
    step(0, 0, 1, 0, 0, "R10");
    step(0, 1, 1, 0, 0, "R9");
    step(0, 1, 1, 0, 0, "R1");

    // R6: disconnect without data before any transfer reads as retry
    step(1, 0, 1, 0, 3, "R6");
    step(0, 1, 1, 0, 0, "R6");
    step(0, 1, 1, 0, 0, "R1");

    // R6: disconnect without data after one transfer
    step(1, 0, 1, 1, 0, "R2");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 0, 1, 0, 3, "R6");
    step(0, 1, 1, 0, 0, "R6");

    // R5: disconnect with data, command ignored while it runs
    step(1, 0, 1, 0, 2, "R5");
    step(0, 0, 1, 0, 4, "R5");
    step(0, 0, 0, 0, 1, "R5");
    step(0, 0, 1, 0, 4, "R10");
    step(0, 1, 1, 0, 0, "R5");

    // R7: abort after select, with R4 retry on the first phase
    step(1, 0, 1, 0, 0, "R2");
    step(0, 0, 1, 0, 4, "R7");
    step(0, 1, 1, 0, 0, "R7");
    step(1, 0, 1, 0, 0, "R2");
    step(0, 0, 1, 0, 1, "R4");
    step(0, 1, 1, 0, 0, "R4");

    // Seeded random mix, weighted toward long transactions
    for (int i = 0; i < 6000; i++) begin
      int r;
      int cmd_r;
      bit cl, fr, ir, rd;
      r     = int'($urandom % 16);
      cmd_r = (r < 10) ? 0 : r - 9;
      cl    = ($urandom % 3) == 0;
      fr    = ($urandom % 5) == 0;
      ir    = ($urandom % 2) == 0;
      rd    = ($urandom % 3) != 0;
      step(cl, fr, ir, rd, cmd_r, "");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule